// File: doc/BRIEF.md
# Thresholded Event Counter with Overflow

This block is one slice of a performance-monitoring unit. A bank of per-cycle event inputs is split into event groups, and each group has several small lanes. A control word picks one group and a lane mask. The masked lanes of that group are summed into a per-cycle increment. The increment then passes through a threshold stage and an optional rising-edge stage, and the result is added to a 44-bit accumulator.

Software reaches the control word, the accumulator and a sticky overflow flag through a simple register port. Writes are single-cycle strobes and reads are combinational. A carry out of the top accumulator bit can raise the flag and send a one-cycle message to a global controller. That controller may answer with a freeze input that stops counting. The accumulator wraps and keeps counting until the freeze arrives, so software can preload 2^44 − N to get an overflow after N events. The accumulator can be read at any time without stopping collection.

Top module: `evc_slice`

## Requirements
- R1: After reset the control word, the accumulator and the overflow flag all read zero, and `ovf_msg` is low.
- R2: Address 0 is the control word. It holds the threshold in bits 31:24, the enable in bit 22, the overflow-enable in bit 20, edge mode in bit 18, the lane mask in 15:8 and the group select in 7:0. Bits 63:32, 23, 21, 19, 17 and 16 always read zero.
- R3: Address 1 is the accumulator. A write loads bits 43:0, and bits 63:43+1 read zero. Address 2 bit 0 is the overflow flag, and address 3 reads zero.
- R4: The increment is the sum of the lanes of the selected group whose mask bit is set. Lane l of group g is `ev_bank[(g*8+l)*2 +: 2]`. A group select of 2 or more yields zero.
- R5: With a threshold of zero, each counting cycle adds the raw increment, and edge mode has no effect.
- R6: With a non-zero threshold, each counting cycle adds 1 when the increment is greater than or equal to the threshold, and adds 0 otherwise.
- R7: With a non-zero threshold and edge mode set, a cycle adds 1 only when the threshold result is true now and was false in the previous clock cycle.
- R8: The accumulator changes only in cycles where the enable bit is 1 and `freeze` is 0.
- R9: Writing a control word with bit 17 set clears the accumulator to zero.
- R10: The accumulator wraps modulo 2^44 and keeps counting after a carry out.
- R11: A carry out while overflow-enable is set raises the overflow flag, and `ovf_msg` is high for exactly the one cycle after that edge. A carry with overflow-enable clear does neither.
- R12: The overflow flag is sticky. Writing 1 to address 2 bit 0 clears it, and a new overflow in the same cycle keeps it set.
- R13: An accumulator write in a counting cycle wins over the increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_bank | input | 32 | Event lanes: 2 groups of 8 lanes, each lane 2 bits wide |
| freeze | input | 1 | Global freeze from the controller; counting stops while high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 accumulator, 2 status |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for `reg_addr` (combinational) |
| ovf_msg | output | 1 | One-cycle overflow message to the global controller |

## Verification
Three pairs of actions can fall in the same clock edge: a carry that sets the overflow flag and a software clear of that flag, an accumulator load and an increment, and the wrap of the accumulator and the message pulse. The bench provokes each pair by opening the freeze gate in the same cycle as the register write, or by preloading the accumulator just below 2^44. It then reads the flag, the accumulator and `ovf_msg` one cycle later. The set must win over the clear, the load must win over the increment, and the wrapped value must agree with arithmetic modulo 2^44.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int THR_W     = 8;
  localparam int SEL_W     = 8;
  localparam int MASK_W    = 8;
  localparam int CTRL_W    = 32;
  localparam int B_THR_LO  = 24;
  localparam int B_EN      = 22;
  localparam int B_OVEN    = 20;
  localparam int B_EDGE    = 18;
  localparam int B_CLR     = 17;
  localparam int B_MASK_LO = 8;
  localparam int B_SEL_LO  = 0;

  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_DATA = 2'd1,
    RA_STS  = 2'd2,
    RA_NONE = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [THR_W-1:0]  thr;
    logic              en;
    logic              ov_en;
    logic              edge_en;
    logic [MASK_W-1:0] umask;
    logic [SEL_W-1:0]  evsel;
  } ctrl_t;

  function automatic ctrl_t ctrl_unpack(input logic [CTRL_W-1:0] w);
    ctrl_t c;
    c.thr     = w[B_THR_LO +: THR_W];
    c.en      = w[B_EN];
    c.ov_en   = w[B_OVEN];
    c.edge_en = w[B_EDGE];
    c.umask   = w[B_MASK_LO +: MASK_W];
    c.evsel   = w[B_SEL_LO +: SEL_W];
    return c;
  endfunction

  function automatic logic [CTRL_W-1:0] ctrl_pack(input ctrl_t c);
    logic [CTRL_W-1:0] w;
    w = '0;
    w[B_THR_LO +: THR_W]   = c.thr;
    w[B_EN]                = c.en;
    w[B_OVEN]              = c.ov_en;
    w[B_EDGE]              = c.edge_en;
    w[B_MASK_LO +: MASK_W] = c.umask;
    w[B_SEL_LO +: SEL_W]   = c.evsel;
    return w;
  endfunction
endpackage

// File: rtl/evc_select.sv
module evc_select import evc_pkg::*; #(
  parameter int NUM_EVENTS = 2,
  parameter int LANES      = 8,
  parameter int LANE_W     = 2,
  parameter int INC_W      = 6,
  localparam int BANK_W    = NUM_EVENTS * LANES * LANE_W,
  localparam int NLANE     = NUM_EVENTS * LANES
) (
  input  logic [BANK_W-1:0] ev_bank,
  input  logic [SEL_W-1:0]  evsel,
  input  logic [MASK_W-1:0] umask,
  output logic [INC_W-1:0]  inc
);
  logic [INC_W-1:0] lane_v [NLANE];

  for (genvar g = 0; g < NUM_EVENTS; g++) begin : g_grp
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign lane_v[g*LANES+l] = ((evsel == SEL_W'(g)) && umask[l])
                                 ? INC_W'(ev_bank[(g*LANES+l)*LANE_W +: LANE_W])
                                 : '0;
    end
  end

  always_comb begin
    inc = '0;
    for (int i = 0; i < NLANE; i++) inc = inc + lane_v[i];
  end
endmodule

// File: rtl/evc_qualify.sv
module evc_qualify import evc_pkg::*; #(
  parameter int INC_W  = 6,
  localparam int CMP_W = (INC_W > THR_W) ? INC_W : THR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [THR_W-1:0] thr,
  input  logic             edge_en,
  input  logic [INC_W-1:0] inc,
  output logic [INC_W-1:0] step
);
  logic thr_on, hit, prev_q, prev_d;

  always_comb begin
    thr_on = (thr != '0);
    hit    = thr_on && (CMP_W'(inc) >= CMP_W'(thr));
    prev_d = hit;
    if (!thr_on)      step = inc;
    else if (edge_en) step = INC_W'(hit && !prev_q);
    else              step = INC_W'(hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  p_unit_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (thr != '0) |-> (step <= INC_W'(1)));
  p_no_repeat_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((thr != '0) && edge_en && $past(hit)) |-> (step == '0));
endmodule

// File: rtl/evc_accum.sv
module evc_accum #(
  parameter int CNT_W = 44,
  parameter int INC_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             clr,
  input  logic             cnt_en,
  input  logic [INC_W-1:0] step,
  input  logic             ov_en,
  input  logic             sts_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf_sts,
  output logic             ovf_msg
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sts_q, sts_d, msg_q, msg_d, carry;
  logic [CNT_W:0]   sum;

  always_comb begin
    sum   = {1'b0, cnt_q} + (CNT_W+1)'(step);
    cnt_d = cnt_q;
    carry = 1'b0;
    if (load)        cnt_d = load_val;
    else if (clr)    cnt_d = '0;
    else if (cnt_en) {carry, cnt_d} = sum;
    msg_d = carry && ov_en;
    sts_d = (sts_q && !sts_clr) || msg_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sts_q <= 1'b0;
      msg_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sts_q <= sts_d;
      msg_q <= msg_d;
    end
  end

  assign cnt     = cnt_q;
  assign ovf_sts = sts_q;
  assign ovf_msg = msg_q;

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !clr && !cnt_en) |=> $stable(cnt_q));
  p_load_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !load) |=> (cnt_q == '0));
  p_msg_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    msg_q |=> !msg_q);
  p_msg_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    msg_q |-> sts_q);
  p_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q && !sts_clr) |=> sts_q);
endmodule

// File: rtl/evc_slice.sv
module evc_slice import evc_pkg::*; #(
  parameter int NUM_EVENTS = 2,
  parameter int LANES      = 8,
  parameter int LANE_W     = 2,
  parameter int CNT_W      = 44,
  parameter int REG_W      = 64,
  localparam int BANK_W    = NUM_EVENTS * LANES * LANE_W,
  localparam int INC_W     = LANE_W + $clog2(LANES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] ev_bank,
  input  logic              freeze,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              ovf_msg
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_i;
  ctrl_t            ctrl_q, ctrl_d;
  reg_addr_e        ra;
  logic             wr_ctrl, wr_data, wr_sts, cnt_clr;
  logic [INC_W-1:0] inc, step;
  logic [CNT_W-1:0] cnt;
  logic             ovf_sts;
  logic             wdata_unused;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  always_comb begin
    ra      = reg_addr_e'(reg_addr);
    wr_ctrl = reg_wr && (ra == RA_CTRL);
    wr_data = reg_wr && (ra == RA_DATA);
    wr_sts  = reg_wr && (ra == RA_STS) && reg_wdata[0];
    cnt_clr = wr_ctrl && reg_wdata[B_CLR];
    ctrl_d  = wr_ctrl ? ctrl_unpack(reg_wdata[CTRL_W-1:0]) : ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) ctrl_q <= '0;
    else          ctrl_q <= ctrl_d;
  end

  assign wdata_unused = ^reg_wdata[REG_W-1:CNT_W];

  evc_select #(
    .NUM_EVENTS(NUM_EVENTS), .LANES(LANES), .LANE_W(LANE_W), .INC_W(INC_W)
  ) i_select (
    .ev_bank(ev_bank), .evsel(ctrl_q.evsel), .umask(ctrl_q.umask), .inc(inc)
  );

  evc_qualify #(.INC_W(INC_W)) i_qualify (
    .clk(clk), .rst_n(rst_n_i), .thr(ctrl_q.thr), .edge_en(ctrl_q.edge_en),
    .inc(inc), .step(step)
  );

  evc_accum #(.CNT_W(CNT_W), .INC_W(INC_W)) i_accum (
    .clk(clk), .rst_n(rst_n_i), .load(wr_data), .load_val(reg_wdata[CNT_W-1:0]),
    .clr(cnt_clr), .cnt_en(ctrl_q.en && !freeze), .step(step),
    .ov_en(ctrl_q.ov_en), .sts_clr(wr_sts), .cnt(cnt), .ovf_sts(ovf_sts),
    .ovf_msg(ovf_msg)
  );

  always_comb begin
    unique case (ra)
      RA_CTRL: reg_rdata = REG_W'(ctrl_pack(ctrl_q));
      RA_DATA: reg_rdata = REG_W'(cnt);
      RA_STS:  reg_rdata = REG_W'(ovf_sts);
      default: reg_rdata = '0;
    endcase
  end

  p_freeze_hold_r8: assert property (@(posedge clk) disable iff (!rst_n_i)
    (freeze && !reg_wr) |=> $stable(cnt));
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(rst_n_i) |-> (!ovf_msg && !ovf_sts));
endmodule

// File: tb/test_evc_slice.sv
module test_evc_slice;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] ev_bank;
  logic        freeze;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [63:0] reg_wdata;
  logic [63:0] reg_rdata;
  logic        ovf_msg;
  int checks = 0;
  int errors = 0;
  bit done = 0;
  localparam logic [63:0] TOP = 64'h1000_0000_0000;

  always #2.5 clk = ~clk;

  evc_slice i_evc_slice (
    .clk(clk), .rst_n(rst_n), .ev_bank(ev_bank), .freeze(freeze),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ovf_msg(ovf_msg)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [63:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [63:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic run(input int n);
    freeze = 1'b0;
    repeat (n) @(negedge clk);
    freeze = 1'b1;
  endtask

  function automatic logic [63:0] cw(input int thr, input bit en, input bit ov,
                                     input bit edg, input bit clr, input int mask,
                                     input int sel);
    logic [63:0] w;
    w = '0;
    w[31:24] = 8'(thr); w[22] = en; w[20] = ov; w[18] = edg; w[17] = clr;
    w[15:8] = 8'(mask); w[7:0] = 8'(sel);
    return w;
  endfunction

  function automatic int exp_sum(input logic [31:0] b, input int sel, input int mask);
    int s;
    s = 0;
    if (sel < 2)
      for (int l = 0; l < 8; l++)
        if (mask[l]) s += int'(b[(sel*8+l)*2 +: 2]);
    return s;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    logic [31:0] seed;
    int masks[6] = '{8'h00, 8'hFF, 8'hA5, 8'h01, 8'h80, 8'h3C};
    int s, e;
    logic [15:0] pat;

    rst_n = 1'b0; freeze = 1'b1; reg_wr = 1'b0; reg_addr = 2'd0;
    reg_wdata = '0; ev_bank = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(2'd0, d); chk("R1 ctrl", d, 0);
    rd(2'd1, d); chk("R1 data", d, 0);
    rd(2'd2, d); chk("R1 status", d, 0);
    chk("R1 msg", 64'(ovf_msg), 0);

    // R2 control readback of defined fields only
    wr(2'd0, '1);
    rd(2'd0, d); chk("R2 ctrl readback", d, 64'h0000_0000_FF54_FFFF);
    wr(2'd0, 0);
    rd(2'd0, d); chk("R2 ctrl cleared", d, 0);

    // R3 data width and unused address
    wr(2'd1, '1);
    rd(2'd1, d); chk("R3 data upper zero", d, 64'h0000_0FFF_FFFF_FFFF);
    rd(2'd3, d); chk("R3 addr3 zero", d, 0);

    // R4 / R5 selection sweep with raw increment
    seed = 32'h1234_5678;
    for (int sel = 0; sel < 4; sel++)
      for (int m = 0; m < 6; m++)
        for (int p = 0; p < 3; p++) begin
          seed = seed * 32'd1664525 + 32'd1013904223;
          wr(2'd0, cw(0, 1, 0, p[0], 0, masks[m], sel));
          wr(2'd1, 0);
          ev_bank = seed;
          run(1);
          rd(2'd1, d);
          chk("R4 R5 selected sum", d, 64'(exp_sum(seed, sel, masks[m])));
        end

    // R6 threshold sweep
    ev_bank = 32'h0000_E4B7;
    s = exp_sum(ev_bank, 0, 8'hFF);
    for (int t = 1; t < 28; t++) begin
      wr(2'd0, cw(t, 1, 0, 0, 0, 8'hFF, 0));
      wr(2'd1, 0);
      run(3);
      rd(2'd1, d);
      chk("R6 threshold", d, (s >= t) ? 64'd3 : 64'd0);
    end

    // R7 edge mode with threshold 1
    ev_bank = '0;
    wr(2'd0, cw(1, 1, 0, 1, 0, 8'hFF, 0));
    wr(2'd1, 0);
    pat = 16'b0110_1110_0101_1001;
    e = 0;
    freeze = 1'b0;
    for (int i = 0; i < 16; i++) begin
      ev_bank = pat[i] ? 32'h0000_FFFF : 32'h0;
      if (pat[i] && (i == 0 || !pat[i-1])) e++;
      @(negedge clk);
    end
    freeze = 1'b1; ev_bank = '0;
    rd(2'd1, d); chk("R7 rising edges", d, 64'(e));
    // R7 held-high event counts once
    wr(2'd1, 0);
    ev_bank = 32'h0000_FFFF;
    run(5);
    rd(2'd1, d); chk("R7 held event", d, 1);
    // R5 edge mode without threshold adds raw value
    wr(2'd0, cw(0, 1, 0, 1, 0, 8'h03, 0));
    wr(2'd1, 0);
    run(3);
    rd(2'd1, d); chk("R5 edge with zero threshold", d, 18);

    // R8 gating
    wr(2'd0, cw(0, 0, 0, 0, 0, 8'hFF, 0));
    wr(2'd1, 7);
    run(4);
    rd(2'd1, d); chk("R8 disabled", d, 7);
    wr(2'd0, cw(0, 1, 0, 0, 0, 8'hFF, 0));
    repeat (3) @(negedge clk);
    rd(2'd1, d); chk("R8 frozen", d, 7);

    // R9 counter clear through control bit 17
    wr(2'd0, cw(0, 1, 0, 0, 1, 8'hFF, 0));
    rd(2'd1, d); chk("R9 cleared", d, 0);
    rd(2'd0, d); chk("R9 bit reads zero", d, cw(0, 1, 0, 0, 0, 8'hFF, 0));

    // R13 load beats increment
    freeze = 1'b0; reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 64'd100;
    @(negedge clk);
    reg_wr = 1'b0; freeze = 1'b1;
    rd(2'd1, d); chk("R13 load wins", d, 100);

    // R10 / R11 overflow with reporting
    ev_bank = 32'h0000_0003;
    wr(2'd0, cw(0, 1, 1, 0, 0, 8'h01, 0));
    wr(2'd1, TOP - 5);
    freeze = 1'b0;
    @(negedge clk);
    chk("R11 no early msg", 64'(ovf_msg), 0);
    @(negedge clk);
    chk("R11 msg on carry", 64'(ovf_msg), 1);
    rd(2'd1, d); chk("R10 wrapped", d, 1);
    @(negedge clk);
    freeze = 1'b1;
    chk("R11 msg one cycle", 64'(ovf_msg), 0);
    rd(2'd1, d); chk("R10 keeps counting", d, 4);
    rd(2'd2, d); chk("R11 flag set", d, 1);

    // R12 clear, then set beats clear
    wr(2'd2, 1);
    rd(2'd2, d); chk("R12 flag cleared", d, 0);
    wr(2'd1, TOP - 2);
    freeze = 1'b0; reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 64'd1;
    @(negedge clk);
    reg_wr = 1'b0; freeze = 1'b1;
    rd(2'd2, d); chk("R12 set beats clear", d, 1);
    wr(2'd2, 1);

    // R11 no report when overflow-enable clear
    wr(2'd0, cw(0, 1, 0, 0, 0, 8'h01, 0));
    wr(2'd1, TOP - 1);
    freeze = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R11 silent without enable", 64'(ovf_msg), 0);
    end
    freeze = 1'b1;
    rd(2'd2, d); chk("R11 flag stays clear", d, 0);
    rd(2'd1, d); chk("R10 wrap without report", d, 8);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule